// File: doc/BRIEF.md
# Page Write Staging Buffer with Timed Commit

This block sits between the serial-bus front end of a byte-addressed non-volatile memory and its storage array. While a write session is open, it gathers the incoming data bytes into a small staging buffer that covers one page. A session opens with a start strobe that carries the first byte address. The page part of that address is fixed for the rest of the session. Each data byte lands at the current in-page offset. The offset then advances and wraps inside the page, so a master that sends more bytes than a page holds overwrites the earliest ones.

When the bus signals a STOP, the block starts one internal write cycle of a fixed length in clock cycles. During that time it reports busy and copies every loaded byte to the array through a single-byte write port. Offsets that were not loaded are never written, so they keep their old contents. A session that ends with an abort (a repeated START) is discarded. A session that ends with a STOP before any byte was loaded starts no write cycle. While busy, every strobe is ignored, so a master can poll until the device is ready again.

Top module: `pgwr_stage`

## Requirements
- R1: After reset, busy is low and mem_we is low.
- R2: sess_start latches the page number from start_addr[12:5] and the in-page offset from start_addr[4:0]. Every array write goes to address {page, offset}.
- R3: Each ld_en pulse stores ld_data at the current offset, then advances the offset by one modulo 32 within the latched page.
- R4: A byte loaded again at an offset it has already used replaces the earlier byte there, and that offset is written to the array once, with the latest data.
- R5: A stop_i pulse with at least one byte loaded raises busy on the next clock for exactly WR_CYCLES clocks. During that window, the loaded bytes are written in ascending offset order, all within the first 32 clocks.
- R6: Offsets that were not loaded in the session are never written, so the array keeps their previous contents.
- R7: abort_i discards all loaded bytes. A stop_i with no byte loaded leaves busy low and causes no write.
- R8: ld_en, sess_start, stop_i and abort_i are ignored while busy is high.
- R9: The record of loaded offsets is cleared when the write cycle ends, so a later stop_i with no new loads starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sess_start | input | 1 | Opens a write session at start_addr |
| start_addr | input | 13 | First byte address of the session |
| ld_en | input | 1 | Data byte strobe |
| ld_data | input | 8 | Data byte |
| stop_i | input | 1 | STOP seen: commit the session |
| abort_i | input | 1 | Repeated START seen: discard the session |
| busy | output | 1 | Internal write cycle in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 13 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The hardest case to reach is a session whose offset wraps past the page end and overwrites bytes that were already loaded. It must still write each offset exactly once, with the last value, and leave the gap of offsets it never reached untouched. The stimulus starts a session two bytes before the page end and loads 35 bytes, so every offset is loaded at least once and the first three are loaded twice. A second session loads a few bytes into the middle of a page that already holds data. The bench then reads back the neighbouring bytes from its array model. Strobes issued in the middle of a write cycle, followed by a STOP with no new loads, show that nothing changed while busy.

// File: rtl/pgwr_stage.sv
module pgwr_stage #(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 32,
  parameter int WR_CYCLES  = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sess_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              ld_en,
  input  logic [7:0]        ld_data,
  input  logic              stop_i,
  input  logic              abort_i,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFF_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [7:0]            stage [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vmask;
  logic [PG_W-1:0]       page;
  logic [OFF_W-1:0]      off;
  logic [CNT_W-1:0]      cnt;

  wire              idle     = !busy;
  wire [OFF_W-1:0]  slot     = cnt[OFF_W-1:0];
  wire              in_sweep = busy && (cnt < CNT_W'(PAGE_BYTES));
  wire              last     = busy && (cnt == CNT_W'(WR_CYCLES - 1));
  wire              do_load  = idle && ld_en && !sess_start && !abort_i && !stop_i;

  assign mem_we    = in_sweep && vmask[slot];
  assign mem_addr  = {page, slot};
  assign mem_wdata = stage[slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      vmask <= '0;
      page  <= '0;
      off   <= '0;
      cnt   <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (last) begin
        busy  <= 1'b0;
        vmask <= '0;
      end
    end else if (abort_i) begin
      vmask <= '0;
    end else if (stop_i) begin
      if (|vmask) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (sess_start) begin
      page  <= start_addr[ADDR_W-1:OFF_W];
      off   <= start_addr[OFF_W-1:0];
      vmask <= '0;
    end else if (ld_en) begin
      vmask[off] <= 1'b1;
      off        <= off + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_load) stage[off] <= ld_data;
  end

  // R5
  commit_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_i) && $past(|vmask));
  // R7
  empty_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && stop_i && vmask == '0) |=> !busy);
  // R7
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && abort_i) |=> (!busy && vmask == '0));
  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> ($stable(vmask) && $stable(page)));
  // R6
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  // R9
  mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> vmask == '0);
endmodule

// File: tb/pgwr_stage_bench.sv
module pgwr_stage_bench;
  localparam int WR = 40;

  logic clk = 0, rst_n = 0;
  logic sess_start = 0, ld_en = 0, stop_i = 0, abort_i = 0;
  logic [12:0] start_addr = '0;
  logic [7:0]  ld_data = '0;
  logic busy, mem_we;
  logic [12:0] mem_addr;
  logic [7:0]  mem_wdata;

  int checks = 0, fails = 0;
  logic [20:0] expq[$];
  logic [7:0] arr [int];
  logic [7:0] shadow [int];

  logic [7:0] bdata [32];
  logic [31:0] bmask = '0;
  logic [7:0] bpage = '0;
  logic [4:0] boff = '0;

  always #4 clk = ~clk;

  pgwr_stage #(.WR_CYCLES(WR)) u_pgwr_stage (.*);

  function automatic logic [7:0] rd(input logic [7:0] pg, input logic [7:0] dummy, input int a);
    return arr.exists(a) ? arr[a] : 8'hFF;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) if (rst_n && mem_we) begin
    logic [20:0] e;
    arr[int'(mem_addr)] = mem_wdata;
    if (expq.size() == 0) chk(0, "R6 unexpected write", {mem_addr, mem_wdata}, 0);
    else begin
      e = expq.pop_front();
      chk({mem_addr, mem_wdata} == e, "R2/R4/R5 write", {mem_addr, mem_wdata}, e);
    end
  end

  task automatic pulse_start(input logic [12:0] a);
    @(negedge clk); sess_start = 1; start_addr = a;
    @(negedge clk); sess_start = 0;
    bpage = a[12:5]; boff = a[4:0]; bmask = '0;
  endtask

  task automatic load(input logic [7:0] d);
    @(negedge clk); ld_en = 1; ld_data = d;
    @(negedge clk); ld_en = 0;
    bdata[boff] = d; bmask[boff] = 1'b1; boff = boff + 1'b1;
  endtask

  task automatic abort_sess();
    @(negedge clk); abort_i = 1;
    @(negedge clk); abort_i = 0;
    bmask = '0;
  endtask

  task automatic commit(input string req);
    int n = 0;
    bit expect_busy = (bmask != 0);
    for (int i = 0; i < 32; i++) if (bmask[i]) begin
      expq.push_back({bpage, 5'(i), bdata[i]});
      shadow[{bpage, 5'(i)}] = bdata[i];
    end
    bmask = '0;
    @(negedge clk); stop_i = 1;
    @(negedge clk); stop_i = 0;
    while (busy && n < 4*WR) begin n++; @(negedge clk); end
    chk(n == (expect_busy ? WR : 0), {req, " busy length"}, n, expect_busy ? WR : 0);
    chk(expq.size() == 0, {req, " pending writes"}, expq.size(), 0);
  endtask

  initial begin
    #(8*200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int a;
    repeat (3) @(negedge clk);
    chk(busy == 0 && mem_we == 0, "R1 reset", {busy, mem_we}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && mem_we == 0, "R1 after reset", {busy, mem_we}, 0);

    // R2 R5 single byte
    pulse_start(13'h0045); load(8'hA5); commit("R2 R5 byte");

    // R3 R4 wrap: start at offset 30, 35 bytes
    pulse_start(13'h1FDE);
    for (int i = 0; i < 35; i++) load(8'(8'h10 + i));
    commit("R3 R4 wrap");

    // R6 partial page over existing data
    pulse_start(13'h1FC7); load(8'h55); load(8'h66); load(8'h77);
    commit("R6 partial");
    for (int i = 0; i < 32; i++) begin
      a = 13'h1FC0 + i;
      chk(rd(0, 0, a) == shadow[a], "R6 readback", rd(0, 0, a), shadow[a]);
    end
    chk(rd(0, 0, 13'h0046) == 8'hFF, "R6 erased neighbour", rd(0, 0, 13'h0046), 8'hFF);

    // R7 abort and empty stop
    pulse_start(13'h0100); load(8'h01); load(8'h02); abort_sess();
    commit("R7 abort");
    pulse_start(13'h0200); commit("R7 empty");

    // R8 strobes during busy ignored, R9 mask cleared
    pulse_start(13'h0300); load(8'h9C);
    for (int i = 0; i < 32; i++) if (i == 0) expq.push_back({8'h18, 5'd0, 8'h9C});
    @(negedge clk); stop_i = 1;
    @(negedge clk); stop_i = 0;
    chk(busy == 1, "R5 busy rises", busy, 1);
    @(negedge clk); sess_start = 1; start_addr = 13'h0400;
    @(negedge clk); sess_start = 0; ld_en = 1; ld_data = 8'hEE;
    @(negedge clk); ld_en = 0; abort_i = 1;
    @(negedge clk); abort_i = 0;
    while (busy) @(negedge clk);
    chk(expq.size() == 0, "R8 write done", expq.size(), 0);
    bmask = '0;
    commit("R8 R9 stop after busy");
    chk(!arr.exists(13'h0400), "R8 ignored load", 0, 0);

    pulse_start(13'h0301); load(8'h3C); commit("R9 fresh session");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule